// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is a master-only synchronous serial controller that works through a queue of up to sixteen pre-loaded transfers without help from the processor. Software fills a transmit word and a command word for each queue slot, programs a start pointer and an end pointer, and then issues a start. For each slot the block drives the selected chip-select lines, shifts the transmit word out most significant bit first on `mosi`, and captures the same number of bits from `miso`. Each received word goes into the receive slot with the same index. When the end slot finishes, a done flag is set and `irq` follows it if interrupts are enabled.

The register bus is a plain synchronous bus. A write takes effect at the clock edge where `bus_sel` and `bus_we` are high. A read returns data on `bus_rdata` one clock after `bus_sel` is high with `bus_we` low. The address map is as follows. Addresses 0x00 to 0x0F hold the transmit words. Addresses 0x10 to 0x1F hold the command words: bits [3:0] are the chip-select pattern, bits [7:4] are the width code, and bit 8 is the keep-select flag. Addresses 0x20 to 0x2F hold the received words and are read-only. Address 0x30 is the configuration register: bits [7:0] set the divider, bit 8 is clock polarity, bit 9 is clock phase, bit 10 is wrap and bit 11 is interrupt enable. Address 0x31 holds the pointers: start in bits [3:0] and end in bits [7:4]. Address 0x32 is the control and status register. Writing bit 0 starts the queue and writing bit 1 clears the done flag. Reading it returns busy in bit 0, done in bit 1 and the current pointer in bits [7:4].

The sequencer has six states. IDLE goes to LOAD on an accepted start. LOAD always goes to SETUP one cycle later. SETUP goes to SHIFT after one half-period tick. SHIFT goes to HOLD on the tick that makes the last clock edge of the word. HOLD, on its tick, goes to IDLE if it was the end slot and wrap is off. Otherwise it goes to LOAD if the keep flag is set, or to GAP if it is not. GAP goes to LOAD on its tick.

Top module: `qspi_queue_master`

## Requirements
- R1: While the block is not busy, all four `cs_n` outputs are high and `sck` rests at the configured polarity, which is 0 after reset. The status register reads 0 after reset.
- R2: The width code in command bits [7:4] selects the number of bits per slot. Codes 8 to 15 give that many bits, code 0 gives 16 bits, and codes 1 to 7 give 8 bits. The low bits of the transmit word are sent, most significant first.
- R3: Each bit sent is matched by one bit captured. The receive slot with the slot's index then holds the captured bits right-aligned, first bit most significant, with the upper bits zero.
- R4: With phase 0, `miso` is sampled on the leading `sck` edge. With phase 1, it is sampled on the trailing edge. `mosi` stays stable across every sampling edge in all four polarity and phase combinations.
- R5: The `sck` half-period is max(divider,1) system clocks. A divider of 0 or 1 therefore gives the fastest rate, half the system clock.
- R6: During a slot, each `cs_n` line whose pattern bit (command bits [3:0]) is 1 is driven low. The pattern stays unchanged for the whole shift.
- R7: Without the keep flag (command bit 8), all `cs_n` lines go high between slots. With it, the lines stay asserted into the next slot. The flag has no effect on the final slot of a run that stops.
- R8: Slots run from the start pointer up to the end pointer, counting modulo 16. When the end slot completes, done (status bit 1) is set, and `irq` equals done ANDed with interrupt enable.
- R9: With wrap set, the queue restarts at the start pointer after the end slot and sets done on each pass. It stops after the end slot that follows software clearing wrap.
- R10: Writing 1 to control bit 1 clears done and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one clock after the read |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| irq | output | 1 | Queue-complete interrupt |

## Verification
The assertions check four things on every cycle. Chip selects stay frozen for as long as a word is shifting. `sck` only changes on a half-period tick while shifting. All selects are released whenever the sequencer is idle. Received words and done events only occur while the queue is busy. The bench's scenarios cover what a single cycle cannot show: the bit order and width clamping of each slot, sampling on the correct edge in all four modes, the measured half-period, whether chip selects are released between slots, pointer wrap from slot 15 to slot 0, and continuous wrapping until software turns it off.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SETUP,
        S_SHIFT,
        S_HOLD,
        S_GAP
    } seq_state_t;

    localparam logic [1:0] BANK_TX  = 2'd0;
    localparam logic [1:0] BANK_CMD = 2'd1;
    localparam logic [1:0] BANK_RX  = 2'd2;
    localparam logic [1:0] BANK_CTL = 2'd3;

endpackage

// File: rtl/qspi_baud.sv
module qspi_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? DIV_W'(1) : div;
    assign tick = en && (cnt == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/qspi_regfile.sv
module qspi_regfile
    import qspi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int CS_W   = 4,
    parameter int DIV_W  = 8,
    parameter int PTR_W  = 4,
    parameter int CMD_W  = 9,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PTR_W-1:0]  cur_ptr,
    input  logic              busy,
    input  logic              rx_we,
    input  logic [PTR_W-1:0]  rx_idx,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              done_set,
    output logic [DATA_W-1:0] tx_word,
    output logic [CMD_W-1:0]  cmd_word,
    output logic [DIV_W-1:0]  div,
    output logic              cpol,
    output logic              cpha,
    output logic              wrap,
    output logic [PTR_W-1:0]  start_ptr,
    output logic [PTR_W-1:0]  end_ptr,
    output logic              go,
    output logic              irq
);

    localparam int CFG_W = DIV_W + 4;
    localparam logic [PTR_W-1:0] REG_CFG = PTR_W'(0);
    localparam logic [PTR_W-1:0] REG_PTR = PTR_W'(1);
    localparam logic [PTR_W-1:0] REG_CTL = PTR_W'(2);

    logic [DATA_W-1:0] tx_mem  [DEPTH];
    logic [CMD_W-1:0]  cmd_mem [DEPTH];
    logic [DATA_W-1:0] rx_mem  [DEPTH];
    logic [CFG_W-1:0]  cfg_q;
    logic [2*PTR_W-1:0] ptr_q;
    logic              done_q;
    logic [1:0]        bank;
    logic [PTR_W-1:0]  idx;
    logic              wr;
    logic              ctl_wr;
    logic [DATA_W-1:0] rd_mux;

    assign bank   = bus_addr[ADDR_W-1 -: 2];
    assign idx    = bus_addr[PTR_W-1:0];
    assign wr     = bus_sel && bus_we;
    assign ctl_wr = wr && (bank == BANK_CTL) && (idx == REG_CTL);
    assign go     = ctl_wr && bus_wdata[0] && !busy;

    assign div       = cfg_q[DIV_W-1:0];
    assign cpol      = cfg_q[DIV_W];
    assign cpha      = cfg_q[DIV_W+1];
    assign wrap      = cfg_q[DIV_W+2];
    assign start_ptr = ptr_q[PTR_W-1:0];
    assign end_ptr   = ptr_q[2*PTR_W-1:PTR_W];
    assign tx_word   = tx_mem[cur_ptr];
    assign cmd_word  = cmd_mem[cur_ptr];
    assign irq       = done_q && cfg_q[DIV_W+3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tx_mem[i]  <= '0;
                cmd_mem[i] <= '0;
                rx_mem[i]  <= '0;
            end
            cfg_q  <= '0;
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr && bank == BANK_TX)  tx_mem[idx]  <= bus_wdata;
            if (wr && bank == BANK_CMD) cmd_mem[idx] <= bus_wdata[CMD_W-1:0];
            if (wr && bank == BANK_CTL && idx == REG_CFG) cfg_q <= bus_wdata[CFG_W-1:0];
            if (wr && bank == BANK_CTL && idx == REG_PTR) ptr_q <= bus_wdata[2*PTR_W-1:0];
            if (rx_we) rx_mem[rx_idx] <= rx_data;
            if (done_set) begin
                done_q <= 1'b1;
            end else if (go || (ctl_wr && bus_wdata[1])) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bank)
            BANK_TX:  rd_mux = tx_mem[idx];
            BANK_CMD: rd_mux = DATA_W'(cmd_mem[idx]);
            BANK_RX:  rd_mux = rx_mem[idx];
            BANK_CTL: begin
                if (idx == REG_CFG) begin
                    rd_mux = DATA_W'(cfg_q);
                end else if (idx == REG_PTR) begin
                    rd_mux = DATA_W'(ptr_q);
                end else if (idx == REG_CTL) begin
                    rd_mux[0]         = busy;
                    rd_mux[1]         = done_q;
                    rd_mux[4 +: PTR_W] = cur_ptr;
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_we) begin
            bus_rdata <= rd_mux;
        end
    end

    // R3
    rx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> busy);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |-> busy);

endmodule

// File: rtl/qspi_sequencer.sv
module qspi_sequencer
    import qspi_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CS_W     = 4,
    parameter int MIN_BITS = 8,
    parameter int PTR_W    = 4,
    parameter int CMD_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic [PTR_W-1:0]  end_ptr,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              wrap,
    input  logic              miso,
    output logic              baud_en,
    output logic              busy,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic              sck,
    output logic              mosi,
    output logic [CS_W-1:0]   cs_n,
    output logic              rx_we,
    output logic [PTR_W-1:0]  rx_idx,
    output logic [DATA_W-1:0] rx_data,
    output logic              done_set
);

    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int EDGE_W = CNT_W + 1;
    localparam int KEEP_B = CS_W + 4;

    seq_state_t        st, nxt;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] txsh;
    logic [DATA_W-1:0] rxsh;
    logic [CNT_W-1:0]  nbits;
    logic [CNT_W-1:0]  sampled;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] last_edge;
    logic [CNT_W-1:0]  ld_bits;
    logic [CS_W-1:0]   cs_q;
    logic              sck_q;
    logic              keep_q;
    logic              at_end;
    logic              do_sample;

    function automatic logic [CNT_W-1:0] width_of(input logic [3:0] code);
        if (code == 4'd0)                    return CNT_W'(DATA_W);
        else if (CNT_W'(code) < MIN_BITS)    return CNT_W'(MIN_BITS);
        else if (CNT_W'(code) > DATA_W)      return CNT_W'(DATA_W);
        else                                 return CNT_W'(code);
    endfunction

    assign ld_bits   = width_of(cmd_word[CS_W+3:CS_W]);
    assign last_edge = {nbits, 1'b0} - EDGE_W'(1);
    assign at_end    = (ptr == end_ptr);
    assign do_sample = ~edge_cnt[0] ^ cpha;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (go) nxt = S_LOAD;
            S_LOAD:  nxt = S_SETUP;
            S_SETUP: if (tick) nxt = S_SHIFT;
            S_SHIFT: if (tick && edge_cnt == last_edge) nxt = S_HOLD;
            S_HOLD: begin
                if (tick) begin
                    if (at_end && !wrap) nxt = S_IDLE;
                    else if (keep_q)     nxt = S_LOAD;
                    else                 nxt = S_GAP;
                end
            end
            S_GAP:   if (tick) nxt = S_LOAD;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= '0;
            txsh     <= '0;
            rxsh     <= '0;
            nbits    <= CNT_W'(MIN_BITS);
            sampled  <= '0;
            edge_cnt <= '0;
            cs_q     <= '1;
            sck_q    <= 1'b0;
            keep_q   <= 1'b0;
            rx_we    <= 1'b0;
            rx_idx   <= '0;
            rx_data  <= '0;
        end else begin
            rx_we <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    cs_q  <= '1;
                    sck_q <= cpol;
                    if (go) ptr <= start_ptr;
                end
                S_LOAD: begin
                    nbits    <= ld_bits;
                    keep_q   <= cmd_word[KEEP_B];
                    cs_q     <= ~cmd_word[CS_W-1:0];
                    txsh     <= tx_word << (CNT_W'(DATA_W) - ld_bits);
                    rxsh     <= '0;
                    sampled  <= '0;
                    edge_cnt <= '0;
                    sck_q    <= cpol;
                end
                S_SETUP: begin
                end
                S_SHIFT: begin
                    if (tick) begin
                        sck_q    <= ~sck_q;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (do_sample) begin
                            rxsh    <= {rxsh[DATA_W-2:0], miso};
                            sampled <= sampled + 1'b1;
                            if (sampled == nbits - 1'b1) begin
                                rx_we   <= 1'b1;
                                rx_idx  <= ptr;
                                rx_data <= {rxsh[DATA_W-2:0], miso};
                            end
                        end else if (!(cpha && edge_cnt == '0)) begin
                            txsh <= {txsh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                S_HOLD: begin
                    if (tick) begin
                        if (at_end && !wrap) begin
                            cs_q <= '1;
                        end else begin
                            ptr <= at_end ? start_ptr : ptr + 1'b1;
                            if (!keep_q) cs_q <= '1;
                        end
                    end
                end
                S_GAP: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign sck      = sck_q;
    assign mosi     = txsh[DATA_W-1];
    assign cs_n     = cs_q;
    assign busy     = (st != S_IDLE);
    assign cur_ptr  = ptr;
    assign baud_en  = (st == S_SETUP) || (st == S_SHIFT) || (st == S_HOLD) || (st == S_GAP);
    assign done_set = (st == S_HOLD) && tick && at_end;

    // R6
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT && $past(st) == S_SHIFT) |-> $stable(cs_q));

    // R5
    sck_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_SHIFT || st == S_HOLD || st == S_GAP) && !$stable(sck_q))
        |-> ($past(st) == S_SHIFT && $past(tick)));

    // R1
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> (cs_q == '1));

endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
    import qspi_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 16,
    parameter int CS_W     = 4,
    parameter int DIV_W    = 8,
    parameter int MIN_BITS = 8,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int ADDR_W  = PTR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_W-1:0]   cs_n,
    output logic              irq
);

    localparam int CMD_W = CS_W + 5;

    logic              go, tick, baud_en, busy, rx_we, done_set;
    logic              cpol, cpha, wrap;
    logic [DIV_W-1:0]  div;
    logic [PTR_W-1:0]  cur_ptr, rx_idx, start_ptr, end_ptr;
    logic [DATA_W-1:0] tx_word, rx_data;
    logic [CMD_W-1:0]  cmd_word;

    qspi_regfile #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .CS_W(CS_W), .DIV_W(DIV_W),
        .PTR_W(PTR_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_ptr(cur_ptr), .busy(busy),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data), .done_set(done_set),
        .tx_word(tx_word), .cmd_word(cmd_word), .div(div),
        .cpol(cpol), .cpha(cpha), .wrap(wrap),
        .start_ptr(start_ptr), .end_ptr(end_ptr), .go(go), .irq(irq)
    );

    qspi_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(baud_en), .div(div), .tick(tick)
    );

    qspi_sequencer #(
        .DATA_W(DATA_W), .CS_W(CS_W), .MIN_BITS(MIN_BITS),
        .PTR_W(PTR_W), .CMD_W(CMD_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
        .tx_word(tx_word), .cmd_word(cmd_word),
        .start_ptr(start_ptr), .end_ptr(end_ptr),
        .cpol(cpol), .cpha(cpha), .wrap(wrap), .miso(miso),
        .baud_en(baud_en), .busy(busy), .cur_ptr(cur_ptr),
        .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data), .done_set(done_set)
    );

endmodule

// File: tb/qspi_queue_master_test.sv
module qspi_queue_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, miso, irq;
    logic [3:0]  cs_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [15:0] tb_tx  [16];
    logic [8:0]  tb_cmd [16];

    // serial slave model state
    bit          cfg_cpol = 1'b0;
    bit          cfg_cpha = 1'b0;
    int          bitpos = 0;
    int          capn = 0;
    logic        cap_bit [1024];
    logic [3:0]  cap_cs  [1024];
    int          last_edge_cyc = -1;
    int          half_min = 1000;
    int          cs_rel = 0;
    logic        prev_idle = 1'b1;

    qspi_queue_master uut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic stream_bit(input int i);
        return logic'((((i * 5) + (i >> 3)) % 3) == 0);
    endfunction

    function automatic int width_of(input logic [3:0] c);
        if (c == 4'd0) return 16;
        if (c < 4'd8)  return 8;
        return int'(c);
    endfunction

    assign miso = stream_bit(bitpos);

    task automatic take_sample();
        if (capn < 1024) begin
            cap_bit[capn] = mosi;
            cap_cs[capn]  = cs_n;
        end
        capn++;
        bitpos++;
    endtask

    always @(posedge sck) if (cs_n != 4'hF && (cfg_cpol == cfg_cpha)) take_sample();
    always @(negedge sck) if (cs_n != 4'hF && (cfg_cpol != cfg_cpha)) take_sample();

    always @(sck) begin
        if (cs_n != 4'hF) begin
            if (last_edge_cyc >= 0 && (cyc - last_edge_cyc) < half_min)
                half_min = cyc - last_edge_cyc;
            last_edge_cyc = cyc;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (&cs_n && !prev_idle) cs_rel++;
        prev_idle = &cs_n;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic load_entry(input int k, input logic [15:0] tx, input logic [3:0] pat,
                              input logic [3:0] code, input bit keep);
        tb_tx[k]  = tx;
        tb_cmd[k] = {keep, code, pat};
        bus_write(6'(k), tx);
        bus_write(6'(16 + k), 16'(tb_cmd[k]));
    endtask

    task automatic wait_status(input int bitn, input bit val);
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            bus_read(6'h32, s);
            if (s[bitn] == val) break;
        end
    endtask

    task automatic arm(input int s, input int e, input bit cpol, input bit cpha,
                       input int div, input bit wrap, input bit ie);
        cfg_cpol = cpol;
        cfg_cpha = cpha;
        bus_write(6'h30, 16'(div & 8'hFF) | (16'(cpol) << 8) | (16'(cpha) << 9)
                         | (16'(wrap) << 10) | (16'(ie) << 11));
        bus_write(6'h31, 16'(s) | (16'(e) << 4));
        repeat (2) @(negedge clk);
        capn = 0; bitpos = 0; half_min = 1000; last_edge_cyc = -1; cs_rel = 0;
    endtask

    // checks every slot from s to e in order against the captured serial traffic
    task automatic check_slots(input string tag, input int s, input int e, input int pos0,
                               output int pos_out);
        int k = s;
        int pos = pos0;
        logic [15:0] got, exp, rxv, rxe;
        bit cs_ok;
        for (int guard = 0; guard < 16; guard++) begin
            int n = width_of(tb_cmd[k][7:4]);
            got = '0; exp = tb_tx[k] & 16'((32'h1 << n) - 1);
            rxe = '0; cs_ok = 1'b1;
            for (int j = 0; j < n; j++) begin
                got = {got[14:0], cap_bit[pos + j]};
                rxe = {rxe[14:0], stream_bit(pos + j)};
                if (cap_cs[pos + j] != ~tb_cmd[k][3:0]) cs_ok = 1'b0;
            end
            // R2 R4: bit order, width and sampling edge on mosi
            chk(got == exp, "R2/R4", $sformatf("%s slot %0d mosi word", tag, k), got, exp);
            // R6: selected lines low for the whole slot
            chk(cs_ok, "R6", $sformatf("%s slot %0d cs pattern", tag, k),
                cap_cs[pos], 4'(~tb_cmd[k][3:0]));
            bus_read(6'(32 + k), rxv);
            // R3: receive slot holds captured bits right-aligned
            chk(rxv == rxe, "R3", $sformatf("%s slot %0d rx word", tag, k), rxv, rxe);
            pos += n;
            if (k == e) break;
            k = (k + 1) % 16;
        end
        pos_out = pos;
    endtask

    task automatic run_queue(input string tag, input int s, input int e, input bit cpol,
                             input bit cpha, input int div, input bit ie, input int exp_rel);
        logic [15:0] st;
        int pos;
        arm(s, e, cpol, cpha, div, 1'b0, ie);
        bus_write(6'h32, 16'h0001);
        wait_status(1, 1'b1);
        wait_status(0, 1'b0);
        repeat (2) @(negedge clk);
        check_slots(tag, s, e, 0, pos);
        chk(capn == pos, "R3", {tag, " total bits"}, capn, pos);
        // R5
        chk(half_min == ((div < 1) ? 1 : div), "R5", {tag, " sck half-period"},
            half_min, (div < 1) ? 1 : div);
        // R7
        chk(cs_rel == exp_rel, "R7", {tag, " cs releases"}, cs_rel, exp_rel);
        // R8
        chk(irq == ie, "R8", {tag, " irq after done"}, irq, ie);
        bus_read(6'h32, st);
        chk(st[1] == 1'b1 && st[0] == 1'b0, "R8", {tag, " status done"}, st[1:0], 2'b10);
        // R1
        chk(cs_n == 4'hF && sck == cpol, "R1", {tag, " idle lines"}, {sck, cs_n}, {cpol, 4'hF});
        // R10
        bus_write(6'h32, 16'h0002);
        bus_read(6'h32, st);
        chk(st[1] == 1'b0 && irq == 1'b0, "R10", {tag, " done cleared"}, {st[1], irq}, 2'b00);
    endtask

    task automatic t_reset();
        logic [15:0] st;
        bus_read(6'h32, st);
        // R1
        chk(cs_n == 4'hF, "R1", "reset cs_n", cs_n, 4'hF);
        chk(sck == 1'b0 && irq == 1'b0, "R1", "reset sck/irq", {sck, irq}, 2'b00);
        chk(st == 16'h0, "R1", "reset status", st, 16'h0);
    endtask

    task automatic t_mode0_plain();
        load_entry(0, 16'hA5C3, 4'b0001, 4'd8, 1'b0);
        load_entry(1, 16'h3C96, 4'b0010, 4'd0, 1'b0);
        load_entry(2, 16'hF5A7, 4'b0100, 4'd12, 1'b0);
        run_queue("mode0", 0, 2, 1'b0, 1'b0, 2, 1'b1, 3);
    endtask

    task automatic t_mode3_keep();
        load_entry(5, 16'h00B4, 4'b1000, 4'd8, 1'b1);
        load_entry(6, 16'h1E2D, 4'b1100, 4'd13, 1'b0);
        run_queue("mode3-keep", 5, 6, 1'b1, 1'b1, 1, 1'b1, 1);
    endtask

    task automatic t_mode1_clamp();
        load_entry(3, 16'hFF5A, 4'b0011, 4'd3, 1'b0);
        load_entry(4, 16'h8001, 4'b1001, 4'd0, 1'b0);
        run_queue("mode1-clamp", 3, 4, 1'b0, 1'b1, 3, 1'b0, 2);
    endtask

    task automatic t_mode2_ptrwrap();
        load_entry(15, 16'h0C3A, 4'b0110, 4'd10, 1'b1);
        load_entry(0,  16'h4BD2, 4'b0110, 4'd15, 1'b1);
        run_queue("mode2-ptrwrap", 15, 0, 1'b1, 1'b0, 0, 1'b1, 1);
    endtask

    task automatic t_wrap();
        logic [15:0] st;
        bit ok = 1'b1;
        load_entry(14, 16'h0069, 4'b0010, 4'd8, 1'b0);
        load_entry(15, 16'h00D2, 4'b0100, 4'd8, 1'b0);
        arm(14, 15, 1'b0, 1'b0, 1, 1'b1, 1'b1);
        bus_write(6'h32, 16'h0001);
        wait_status(1, 1'b1);
        bus_read(6'h32, st);
        // R9: still running after first end slot
        chk(st[0] == 1'b1, "R9", "wrap busy after first done", st[0], 1'b1);
        repeat (100) @(negedge clk);
        bus_write(6'h30, 16'h0001 | 16'h0800);
        wait_status(0, 1'b0);
        repeat (2) @(negedge clk);
        // R9
        chk(capn >= 32 && (capn % 16) == 0, "R9", "wrap total bits", capn, 32);
        for (int p = 0; p < 4; p++) begin
            logic [7:0] w = '0;
            logic [7:0] e = (p % 2 == 0) ? 8'h69 : 8'hD2;
            for (int j = 0; j < 8; j++) w = {w[6:0], cap_bit[p * 8 + j]};
            if (w != e) ok = 1'b0;
        end
        chk(ok, "R9", "wrap repeated slots", ok, 1'b1);
        chk(irq == 1'b1, "R8", "wrap irq", irq, 1'b1);
        bus_write(6'h32, 16'h0002);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mode0_plain();
        t_mode3_keep();
        t_mode1_clamp();
        t_mode2_ptrwrap();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule